// File: doc/BRIEF.md
# Four-Channel PCM Time-Slot Interface

This block joins four voice channels to a synchronous serial PCM highway. A frame holds up to 256 slots of eight bits each. A frame strobe, common to all channels, starts every frame. Each channel has one slot in which its byte goes out on the transmit pin and another slot, chosen on its own, from which a byte is taken off the receive pin. The two directions use separate pins, so the highway runs as a 4-wire bus. A frame may hold fewer than 256 slots: the next strobe restarts the count wherever it is.

The block is clocked directly by the bit clock. Transmit bits leave on the rising edge, most significant bit first. Receive bits are sampled on the falling edge. The block never drives the transmit pin itself. It raises an output enable for the bit periods that belong to an active channel, and a pad tristate buffer uses that enable. Software sets each channel's two slot numbers and two enable bits through a small write port. Captured bytes go to the channel side with a one-cycle valid pulse. The channel side keeps a byte ready on its transmit input for each channel.

Top module: `pcm_tsi4`

## Requirements
- R1: While reset is low, and after reset until the first frame strobe, `tx_oe` and every `rx_valid` bit stay low. Reset is asynchronous and clears every channel's configuration to disabled.
- R2: When the frame strobe is high at a rising edge, that edge opens bit 0 of slot 0. Each slot lasts 8 bit periods. Slots are numbered up to 255 and the count wraps after slot 255. A strobe restarts the count at any point, which allows shorter frames.
- R3: During the 8 bit periods of a slot owned by a channel, `tx_oe` is high and `tx_data` carries the byte most significant bit first, launched at each rising edge. Outside owned slots, `tx_oe` is low.
- R4: The transmit byte is taken from the channel's lane of `tx_bytes` at the rising edge that opens the slot. Changes to that lane later in the slot do not alter the bits sent.
- R5: `rx_data` is sampled on each falling edge and shifted in most significant bit first. After the eighth bit of a channel's receive slot is sampled, the next rising edge raises that channel's `rx_valid` bit for one cycle. At the same edge it places the byte in the channel's lane of `rx_bytes`, where it stays until the next capture.
- R6: The transmit slot and the receive slot of a channel are independent of each other. Several channels may receive the same slot, and each of them gets the byte.
- R7: A channel whose transmit enable is clear never raises `tx_oe`. A channel whose receive enable is clear never pulses `rx_valid`, whatever its slot numbers are.
- R8: When several enabled channels are set to the same transmit slot, only the lowest-numbered of them sends its byte.
- R9: A write with `wr_en` high stores `wr_data` into a configuration register. `wr_addr[2:1]` selects the channel and `wr_addr[0]` selects the direction (0 transmit, 1 receive). `wr_data[8]` is the enable and `wr_data[7:0]` is the slot number. The new setting applies from the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock; transmit launches on the rising edge, receive samples on the falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs | input | 1 | Frame strobe, synchronous to the bit clock |
| rx_data | input | 1 | Receive serial data from the highway |
| tx_data | output | 1 | Transmit serial data toward the pad |
| tx_oe | output | 1 | Pad output enable for `tx_data` |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Channel in bits 2:1, direction in bit 0 |
| wr_data | input | 9 | Enable in bit 8, slot number in bits 7:0 |
| tx_bytes | input | 32 | Transmit byte for each channel, channel n in bits 8n+7:8n |
| rx_bytes | output | 32 | Last captured byte for each channel, channel n in bits 8n+7:8n |
| rx_valid | output | 4 | One-cycle capture pulse for each channel |

## Verification
An error in the bit or slot counter shows up at the pins within the current slot. `tx_oe` then rises or falls at a bit other than the first bit of a slot, or the byte appears one slot off, and a wrong count right after a strobe shows at the very next edge. A wrong owner choice, or a stale transmit byte, gives a wrong bit on `tx_data` during the slot itself. A fault in the receive shift register or its slot match shows one edge after the eighth bit, as a missing or misplaced `rx_valid` pulse or a wrong byte. Frames of 16 slots and of the full 256 slots are run, so both the strobe restart and the wrap at the top of the count are exercised.

// File: rtl/pcm_tsi_pkg.sv
package pcm_tsi_pkg;
  // slot numbering and bits per slot
  localparam int unsigned SLOT_W    = 8;
  localparam int unsigned BIT_W     = 3;
  localparam int unsigned SLOT_BITS = 1 << BIT_W;

  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] slot;
  } slot_cfg_t;

  // channel owns this slot in this direction
  function automatic logic cfg_hits(slot_cfg_t c, logic [SLOT_W-1:0] s);
    return c.en && (c.slot == s);
  endfunction

  // bit position in the byte sent at a given bit period, MSB first
  function automatic logic [BIT_W-1:0] msb_first_index(logic [BIT_W-1:0] b);
    return ~b;
  endfunction
endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
  import pcm_tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs,
  output logic [BIT_W-1:0]  cur_bit,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              synced,
  output logic [BIT_W-1:0]  nxt_bit,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic              nxt_synced
);
  logic last_bit;
  assign last_bit = &cur_bit;

  // position of the bit period that the current rising edge opens
  always_comb begin
    if (fs) begin
      nxt_bit  = '0;
      nxt_slot = '0;
    end else begin
      nxt_bit  = cur_bit + 1'b1;
      nxt_slot = last_bit ? cur_slot + 1'b1 : cur_slot;
    end
    nxt_synced = synced | fs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_bit  <= '1;
      cur_slot <= '1;
      synced   <= 1'b0;
    end else begin
      cur_bit  <= nxt_bit;
      cur_slot <= nxt_slot;
      synced   <= nxt_synced;
    end
  end
endmodule

// File: rtl/pcm_tx_serializer.sv
module pcm_tx_serializer
  import pcm_tsi_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [BIT_W-1:0]            nxt_bit,
  input  logic [SLOT_W-1:0]           nxt_slot,
  input  logic                        nxt_synced,
  input  slot_cfg_t [NUM_CH-1:0]      cfg,
  input  logic [NUM_CH*SLOT_BITS-1:0] bytes_in,
  output logic                        tx_data,
  output logic                        tx_oe
);
  logic                 hit;
  logic [SLOT_BITS-1:0] win_byte;
  logic [SLOT_BITS-1:0] shreg;

  // lowest-numbered enabled channel on this slot owns the pin
  always_comb begin
    hit      = 1'b0;
    win_byte = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cfg_hits(cfg[i], nxt_slot)) begin
        hit      = 1'b1;
        win_byte = bytes_in[i*SLOT_BITS +: SLOT_BITS];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_oe   <= 1'b0;
      tx_data <= 1'b0;
      shreg   <= '0;
    end else begin
      tx_oe <= nxt_synced & hit;
      if (nxt_bit == '0) begin
        shreg   <= win_byte;
        tx_data <= win_byte[msb_first_index(nxt_bit)];
      end else begin
        tx_data <= shreg[msb_first_index(nxt_bit)];
      end
    end
  end
endmodule

// File: rtl/pcm_rx_deserializer.sv
module pcm_rx_deserializer
  import pcm_tsi_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rx_data,
  input  logic [BIT_W-1:0]            cur_bit,
  input  logic [SLOT_W-1:0]           cur_slot,
  input  logic                        synced,
  input  slot_cfg_t [NUM_CH-1:0]      cfg,
  output logic [NUM_CH*SLOT_BITS-1:0] bytes_out,
  output logic [NUM_CH-1:0]           valid
);
  logic rx_q;
  logic last_bit;
  assign last_bit = &cur_bit;

  // falling-edge sample of the highway
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b0;
    else        rx_q <= rx_data;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    logic [SLOT_BITS-1:0] shreg;
    logic [SLOT_BITS-1:0] held;
    logic                 pulse;
    logic                 capture;

    assign capture = synced && cfg_hits(cfg[ch], cur_slot);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shreg <= '0;
        held  <= '0;
        pulse <= 1'b0;
      end else begin
        pulse <= capture && last_bit;
        if (capture) begin
          shreg <= {shreg[SLOT_BITS-2:0], rx_q};
          if (last_bit) held <= {shreg[SLOT_BITS-2:0], rx_q};
        end
      end
    end

    assign bytes_out[ch*SLOT_BITS +: SLOT_BITS] = held;
    assign valid[ch] = pulse;
  end
endmodule

// File: rtl/pcm_tsi4.sv
module pcm_tsi4
  import pcm_tsi_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned ADDR_W = CH_W + 1,
  localparam int unsigned DATA_W = SLOT_W + 1,
  localparam int unsigned LANE_W = NUM_CH * SLOT_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs,
  input  logic              rx_data,
  output logic              tx_data,
  output logic              tx_oe,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANE_W-1:0] tx_bytes,
  output logic [LANE_W-1:0] rx_bytes,
  output logic [NUM_CH-1:0] rx_valid
);
  slot_cfg_t [NUM_CH-1:0] tx_cfg;
  slot_cfg_t [NUM_CH-1:0] rx_cfg;

  // named events for the checker
  logic [BIT_W-1:0]  cur_bit, nxt_bit;
  logic [SLOT_W-1:0] cur_slot, nxt_slot;
  logic              synced, nxt_synced;
  logic              tx_any_en;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cfg
    logic sel;
    assign sel = wr_en && (wr_addr[ADDR_W-1:1] == CH_W'(ch));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tx_cfg[ch] <= '0;
        rx_cfg[ch] <= '0;
      end else if (sel) begin
        if (wr_addr[0]) rx_cfg[ch] <= slot_cfg_t'(wr_data);
        else            tx_cfg[ch] <= slot_cfg_t'(wr_data);
      end
    end
  end

  always_comb begin
    tx_any_en = 1'b0;
    for (int i = 0; i < NUM_CH; i++) tx_any_en |= tx_cfg[i].en;
  end

  pcm_slot_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .fs         (fs),
    .cur_bit    (cur_bit),
    .cur_slot   (cur_slot),
    .synced     (synced),
    .nxt_bit    (nxt_bit),
    .nxt_slot   (nxt_slot),
    .nxt_synced (nxt_synced)
  );

  pcm_tx_serializer #(.NUM_CH(NUM_CH)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .nxt_bit    (nxt_bit),
    .nxt_slot   (nxt_slot),
    .nxt_synced (nxt_synced),
    .cfg        (tx_cfg),
    .bytes_in   (tx_bytes),
    .tx_data    (tx_data),
    .tx_oe      (tx_oe)
  );

  pcm_rx_deserializer #(.NUM_CH(NUM_CH)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_data   (rx_data),
    .cur_bit   (cur_bit),
    .cur_slot  (cur_slot),
    .synced    (synced),
    .cfg       (rx_cfg),
    .bytes_out (rx_bytes),
    .valid     (rx_valid)
  );
endmodule

// File: rtl/pcm_tsi4_checker.sv
module pcm_tsi4_checker
  import pcm_tsi_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs,
  input logic              tx_oe,
  input logic [NUM_CH-1:0] rx_valid,
  input logic [BIT_W-1:0]  cur_bit,
  input logic [SLOT_W-1:0] cur_slot,
  input logic              synced,
  input logic              tx_any_en
);
  // R1: pin never driven before the first strobe
  assert_no_drive_unsynced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> !tx_oe);

  // R2: strobe opens bit 0 of slot 0
  assert_strobe_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fs |=> (cur_bit == '0 && cur_slot == '0));

  // R3: enable changes only on slot boundaries
  assert_oe_rise_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> cur_bit == '0);
  assert_oe_fall_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_oe) |-> cur_bit == '0);

  // R5: capture follows the eighth bit and lasts one cycle
  assert_valid_after_last_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |-> ($past(cur_bit) == '1));
  assert_valid_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |=> !(|rx_valid));

  // R7: no enable without some enabled transmit channel
  assert_oe_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |-> $past(tx_any_en));
endmodule

bind pcm_tsi4 pcm_tsi4_checker #(.NUM_CH(NUM_CH)) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .fs        (fs),
  .tx_oe     (tx_oe),
  .rx_valid  (rx_valid),
  .cur_bit   (cur_bit),
  .cur_slot  (cur_slot),
  .synced    (synced),
  .tx_any_en (tx_any_en)
);

// File: tb/pcm_tsi4_test.sv
`timescale 1ns/1ps
module pcm_tsi4_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic        rx_data = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [8:0]  wr_data = '0;
  logic [31:0] tx_bytes = '0;
  wire         tx_data, tx_oe;
  wire  [31:0] rx_bytes;
  wire  [3:0]  rx_valid;

  always #2 clk = ~clk;

  pcm_tsi4 uut (
    .clk(clk), .rst_n(rst_n), .fs(fs), .rx_data(rx_data),
    .tx_data(tx_data), .tx_oe(tx_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_bytes(tx_bytes), .rx_bytes(rx_bytes), .rx_valid(rx_valid)
  );

  // {tx_en[3:0], rx_en[3:0], tx slots ch3..ch0, rx slots ch3..ch0}
  localparam int NVEC = 6;
  localparam logic [71:0] VEC [NVEC] = '{
    {4'b0001, 4'b0001, 8'd0,  8'd0, 8'd0, 8'd3,  8'd0, 8'd0,  8'd0, 8'd3},
    {4'b1111, 4'b1111, 8'd14, 8'd9, 8'd5, 8'd0,  8'd7, 8'd13, 8'd2, 8'd1},
    {4'b1111, 4'b0110, 8'd10, 8'd4, 8'd4, 8'd4,  8'd0, 8'd6,  8'd6, 8'd0},
    {4'b0100, 4'b0000, 8'd0,  8'd2, 8'd2, 8'd0,  8'd3, 8'd3,  8'd3, 8'd3},
    {4'b1000, 4'b0001, 8'd15, 8'd0, 8'd0, 8'd0,  8'd0, 8'd0,  8'd0, 8'd0},
    {4'b0011, 4'b1000, 8'd0,  8'd0, 8'd1, 8'd0,  8'd8, 8'd0,  8'd0, 8'd0}
  };

  int n_chk = 0;
  int n_bad = 0;
  int cur_v = 0;
  string tag = "";
  int m_tx_slot [4];
  int m_rx_slot [4];
  bit m_tx_en [4];
  bit m_rx_en [4];
  logic [7:0] m_txb [4];

  function automatic logic [7:0] gen_tx(int v, int ch);
    return 8'((v * 37 + ch * 91) ^ 8'hA5);
  endfunction

  function automatic logic [7:0] gen_rx(int v, int s);
    return 8'((s * 29) ^ (v * 11) ^ 8'h3C);
  endfunction

  task automatic check_eq(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, req, act, exp);
    end
  endtask

  task automatic set_cfg(int ch, int dir, bit en, int slot);
    @(posedge clk); #1;
    wr_en   = 1'b1;
    wr_addr = {2'(ch), 1'(dir)};
    wr_data = {en, 8'(slot)};
    if (dir == 0) begin m_tx_en[ch] = en; m_tx_slot[ch] = slot; end
    else          begin m_rx_en[ch] = en; m_rx_slot[ch] = slot; end
  endtask

  task automatic load_bytes();
    for (int ch = 0; ch < 4; ch++) begin
      m_txb[ch] = gen_tx(cur_v, ch);
      tx_bytes[ch*8 +: 8] = m_txb[ch];
    end
  endtask

  task automatic start_frame();
    @(posedge clk); #1;
    wr_en = 1'b0;
    fs    = 1'b1;
  endtask

  // expected pins for bit period p, derived from the requirements
  task automatic check_period(int p);
    int slot = p / 8;
    int b    = p % 8;
    int own  = -1;
    for (int ch = 3; ch >= 0; ch--)
      if (m_tx_en[ch] && m_tx_slot[ch] == slot) own = ch;   // R8 lowest wins
    check_eq("R3 R7 R8 R9 tx_oe", {31'd0, tx_oe}, {31'd0, own >= 0});
    if (own >= 0)
      check_eq("R3 R4 tx_data", {31'd0, tx_data}, {31'd0, m_txb[own][7-b]});
    for (int ch = 0; ch < 4; ch++) begin
      bit exp_v = (p >= 1) && ((p - 1) % 8 == 7) && m_rx_en[ch]
                  && (m_rx_slot[ch] == (p - 1) / 8);
      check_eq("R5 R6 R7 rx_valid", {31'd0, rx_valid[ch]}, {31'd0, exp_v});
      if (exp_v)
        check_eq("R5 R6 rx_bytes", {24'd0, rx_bytes[ch*8 +: 8]},
                 {24'd0, gen_rx(cur_v, (p - 1) / 8)});
    end
  endtask

  task automatic run_frame(int nslots, int mid_p, int mid_ch, logic [7:0] mid_byte);
    for (int p = 0; p < nslots * 8; p++) begin
      logic [7:0] rb;
      @(posedge clk); #1;
      fs = 1'b0;
      rb = gen_rx(cur_v, p / 8);
      rx_data = rb[7 - p % 8];
      if (p == mid_p) tx_bytes[mid_ch*8 +: 8] = mid_byte;
      #2;
      check_period(p);
    end
  endtask

  task automatic apply_vec(int v);
    logic [71:0] w = VEC[v];
    cur_v = v;
    for (int ch = 0; ch < 4; ch++)
      set_cfg(ch, 0, w[68 + ch], int'(w[32 + ch*8 +: 8]));
    for (int ch = 0; ch < 4; ch++)
      set_cfg(ch, 1, w[64 + ch], int'(w[ch*8 +: 8]));
    load_bytes();
    start_frame();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    finish_run();
  end

  initial begin
    for (int ch = 0; ch < 4; ch++) begin
      m_tx_en[ch] = 0; m_rx_en[ch] = 0; m_tx_slot[ch] = 0; m_rx_slot[ch] = 0;
    end
    // R1: outputs quiet during reset
    tag = "reset";
    repeat (3) @(posedge clk);
    #3;
    check_eq("R1 tx_oe in reset", {31'd0, tx_oe}, 32'd0);
    check_eq("R1 rx_valid in reset", {28'd0, rx_valid}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1: configured but no strobe yet
    tag = "unsynced";
    set_cfg(0, 0, 1, 0);
    set_cfg(0, 1, 1, 0);
    @(posedge clk); #1 wr_en = 1'b0;
    for (int i = 0; i < 24; i++) begin
      @(posedge clk); #1 rx_data = i[0];
      #2;
      check_eq("R1 tx_oe before strobe", {31'd0, tx_oe}, 32'd0);
      check_eq("R1 rx_valid before strobe", {28'd0, rx_valid}, 32'd0);
    end

    // table of slot layouts, 16-slot frames (R2 short frame)
    for (int v = 0; v < NVEC; v++) begin
      tag = $sformatf("R2 vec%0d", v);
      apply_vec(v);
      run_frame(16, -1, 0, 8'h00);
    end

    // R4: lane change in mid-slot is not sent
    tag = "R4 midslot";
    cur_v = 10;
    for (int ch = 0; ch < 4; ch++) begin
      set_cfg(ch, 0, ch == 1, 2);
      set_cfg(ch, 1, ch == 2, 5);
    end
    load_bytes();
    start_frame();
    run_frame(16, 19, 1, ~m_txb[1]);

    // R2: full 256-slot frame, top slots
    tag = "R2 fullframe";
    cur_v = 11;
    set_cfg(0, 0, 1, 128);
    set_cfg(1, 0, 0, 0);
    set_cfg(2, 0, 1, 255);
    set_cfg(3, 0, 0, 0);
    set_cfg(0, 1, 0, 0);
    set_cfg(1, 1, 1, 254);
    set_cfg(2, 1, 0, 0);
    set_cfg(3, 1, 1, 0);
    load_bytes();
    start_frame();
    run_frame(256, -1, 0, 8'h00);

    // R1: asynchronous reset while driving clears outputs and configuration
    tag = "R1 midreset";
    cur_v = 12;
    for (int ch = 0; ch < 4; ch++) begin
      set_cfg(ch, 0, ch == 0, 2);
      set_cfg(ch, 1, 0, 0);
    end
    load_bytes();
    start_frame();
    run_frame(2, -1, 0, 8'h00);
    @(posedge clk); #1 rst_n = 1'b0;
    #1;
    check_eq("R1 tx_oe after async reset", {31'd0, tx_oe}, 32'd0);
    check_eq("R1 rx_valid after async reset", {28'd0, rx_valid}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    for (int ch = 0; ch < 4; ch++) begin m_tx_en[ch] = 0; m_rx_en[ch] = 0; end
    start_frame();
    run_frame(16, -1, 0, 8'h00);

    finish_run();
  end
endmodule